// File: doc/BRIEF.md
# SIMT Execution Mask Stack

This block tracks which lanes of a SIMD warp take part in each instruction while the warp runs nested, structured control flow. Each lane owns one activity bit in the execution mask. Conditionals and loops narrow the mask, and a hardware stack of saved masks restores it when a region closes. The stack stores both the enclosing mask and the branch condition for each level, so the else-side mask can be formed later.

The sequencer issues one command per cycle on a small command port. Each command is a conditional open, the switch to the else side, a conditional close, a loop entry, a loop test carrying per-lane conditions, or a loop close. The block returns several outputs:

- the registered lane mask;
- a skip flag that tells fetch to jump past a region no lane executes;
- a pulse that marks a condition as uniform across the active lanes, so it can be taken as a scalar branch;
- a loop-repeat pulse;
- sticky overflow and underflow flags.

Top module: `simt_mask_unit`

## Requirements
- R1: After synchronous reset the mask is all ones, the stack is empty, and skip, uniform, loop_repeat, err_overflow and err_underflow are all 0.
- R2: Command code 1 (conditional open) pushes the current mask together with `cond`, and sets the mask to current AND `cond`.
- R3: Command code 2 (else) sets the mask to the saved enclosing mask AND NOT the saved condition, and leaves the stack unchanged. With an enclosing mask of 0x0F and a then-condition of 0x05, the else mask is 0x0A.
- R4: Command code 3 (conditional close) pops the stack and restores the saved enclosing mask.
- R5: `skip` is 1 exactly while the mask is all zeros.
- R6: On an accepted command 1 or 5, `uniform` pulses to 1 for one cycle when (mask AND cond) equals the mask or equals zero. It is 0 after every other command.
- R7: Command code 4 (loop entry) pushes the current mask and leaves the mask unchanged. Command code 5 (loop test) sets the mask to current AND `cond` and does not touch the stack.
- R8: On command code 6 (loop close), if any lane is still active, `loop_repeat` pulses to 1 and the mask and stack stay the same. Otherwise the stack pops, the mask saved at loop entry is restored, and `loop_repeat` is 0.
- R9: A push (codes 1 and 4) when the stack already holds DEPTH entries sets the sticky `err_overflow` flag and changes neither the mask nor the stack.
- R10: Codes 2, 3 and 6 on an empty stack set the sticky `err_underflow` flag and change neither the mask nor the stack.
- R11: A new mask formed by codes 1 or 5 never turns on a lane that was off before.
- R12: Code 0, code 7, or `cmd_valid` low leaves the mask and the stack unchanged, and `uniform` and `loop_repeat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command is presented this cycle |
| cmd | input | 3 | Command code (0 none, 1 open, 2 else, 3 close, 4 loop entry, 5 loop test, 6 loop close, 7 none) |
| cond | input | LANES | Per-lane condition for codes 1 and 5 |
| exec_mask | output | LANES | Registered per-lane execution mask |
| skip | output | 1 | Mask is all zeros, so fetch may jump past the region |
| uniform | output | 1 | The last condition did not split the active lanes |
| loop_repeat | output | 1 | The last loop close branches back |
| err_overflow | output | 1 | Sticky: a push was attempted on a full stack |
| err_underflow | output | 1 | Sticky: a pop or top read was attempted on an empty stack |

## Verification
Every result of a command sampled at clock edge k appears on the outputs right after edge k. This covers the mask, the skip flag, the uniform and repeat pulses, and the error flags. None of them has further delay. The bench drives each command at a falling edge and compares all outputs at the next falling edge, half a cycle after the edge that registered them. It then drives the following command at that same falling edge, so commands run back to back. The expected values come from a reference stack model in the bench, which is updated once per driven command.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_OPEN       = 3'd1,
        CMD_OTHER_SIDE = 3'd2,
        CMD_CLOSE      = 3'd3,
        CMD_LOOP_ENTER = 3'd4,
        CMD_LOOP_TEST  = 3'd5,
        CMD_LOOP_CLOSE = 3'd6,
        CMD_SPARE      = 3'd7
    } ctl_cmd_e;

    typedef struct packed {
        logic wants_push;
        logic wants_pop;
        logic reads_top;
        logic applies_cond;
    } cmd_class_t;

    function automatic ctl_cmd_e qualify_cmd(input logic valid, input logic [2:0] raw);
        ctl_cmd_e c;
        c = ctl_cmd_e'(raw);
        if (!valid || c == CMD_SPARE) c = CMD_NONE;
        return c;
    endfunction

    function automatic cmd_class_t classify_cmd(input ctl_cmd_e c);
        cmd_class_t k;
        k = '0;
        case (c)
            CMD_OPEN:       begin k.wants_push = 1'b1; k.applies_cond = 1'b1; end
            CMD_LOOP_ENTER: k.wants_push = 1'b1;
            CMD_OTHER_SIDE: k.reads_top = 1'b1;
            CMD_CLOSE:      begin k.reads_top = 1'b1; k.wants_pop = 1'b1; end
            CMD_LOOP_CLOSE: k.reads_top = 1'b1;
            CMD_LOOP_TEST:  k.applies_cond = 1'b1;
            default:        k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
    parameter int LANES = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [LANES-1:0] push_mask,
    input  logic [LANES-1:0] push_cond,
    output logic [LANES-1:0] top_mask,
    output logic [LANES-1:0] top_cond,
    output logic             empty,
    output logic             full
);
    localparam int PW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LANES-1:0] saved;
        logic [LANES-1:0] cond;
    } level_t;

    level_t          level_q [DEPTH];
    logic [PW-1:0]   sp_q;

    assign empty = (sp_q == '0);
    assign full  = (sp_q == PW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (push && !full) begin
            sp_q <= sp_q + PW'(1);
        end else if (pop && !empty) begin
            sp_q <= sp_q - PW'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_level
        always_ff @(posedge clk) begin
            if (rst) begin
                level_q[g] <= '0;
            end else if (push && !full && sp_q == PW'(g)) begin
                level_q[g].saved <= push_mask;
                level_q[g].cond  <= push_cond;
            end
        end
    end

    always_comb begin
        top_mask = '0;
        top_cond = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == PW'(i + 1)) begin
                top_mask = level_q[i].saved;
                top_cond = level_q[i].cond;
            end
        end
    end

endmodule

// File: rtl/simt_mask_next.sv
module simt_mask_next
    import simt_mask_pkg::*;
#(
    parameter int LANES = 8
) (
    input  ctl_cmd_e         cmd,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] top_mask,
    input  logic [LANES-1:0] top_cond,
    input  logic             empty,
    input  logic             full,
    output logic [LANES-1:0] nxt_mask,
    output logic [LANES-1:0] push_cond,
    output logic             push,
    output logic             pop,
    output logic             accepted,
    output logic             ovf_evt,
    output logic             unf_evt,
    output logic             repeat_nxt
);
    cmd_class_t cls;
    logic       any_active;

    assign cls        = classify_cmd(cmd);
    assign any_active = |cur_mask;
    assign push_cond  = (cmd == CMD_OPEN) ? cond : '1;

    always_comb begin
        nxt_mask   = cur_mask;
        push       = 1'b0;
        pop        = 1'b0;
        ovf_evt    = 1'b0;
        unf_evt    = 1'b0;
        repeat_nxt = 1'b0;
        accepted   = 1'b0;
        if (cls.wants_push && full) begin
            ovf_evt = 1'b1;
        end else if (cls.reads_top && empty) begin
            unf_evt = 1'b1;
        end else begin
            accepted = (cmd != CMD_NONE);
            case (cmd)
                CMD_OPEN: begin
                    push     = 1'b1;
                    nxt_mask = cur_mask & cond;
                end
                CMD_LOOP_ENTER: push = 1'b1;
                CMD_OTHER_SIDE: nxt_mask = top_mask & ~top_cond;
                CMD_CLOSE: begin
                    pop      = 1'b1;
                    nxt_mask = top_mask;
                end
                CMD_LOOP_TEST: nxt_mask = cur_mask & cond;
                CMD_LOOP_CLOSE: begin
                    if (any_active) begin
                        repeat_nxt = 1'b1;
                    end else begin
                        pop      = 1'b1;
                        nxt_mask = top_mask;
                    end
                end
                default: nxt_mask = cur_mask;
            endcase
        end
    end

endmodule

// File: rtl/simt_uniform_detect.sv
module simt_uniform_detect #(
    parameter int LANES = 8
) (
    input  logic             eval,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] cond,
    output logic             uniform
);
    logic [LANES-1:0] taken;
    logic             all_taken;
    logic             none_taken;

    assign taken      = cur_mask & cond;
    assign all_taken  = (taken == cur_mask);
    assign none_taken = (taken == '0);
    assign uniform    = eval && (all_taken || none_taken);

endmodule

// File: rtl/simt_mask_unit.sv
module simt_mask_unit
    import simt_mask_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] exec_mask,
    output logic             skip,
    output logic             uniform,
    output logic             loop_repeat,
    output logic             err_overflow,
    output logic             err_underflow
);
    ctl_cmd_e         cmd_q;
    cmd_class_t       cls;
    logic [LANES-1:0] mask_q;
    logic [LANES-1:0] nxt_mask;
    logic [LANES-1:0] top_mask;
    logic [LANES-1:0] top_cond;
    logic [LANES-1:0] push_cond;
    logic             empty;
    logic             full;
    logic             push;
    logic             pop;
    logic             accepted;
    logic             ovf_evt;
    logic             unf_evt;
    logic             repeat_nxt;
    logic             uni_nxt;
    logic             uni_q;
    logic             rep_q;
    logic             ovf_q;
    logic             unf_q;

    assign cmd_q = qualify_cmd(cmd_valid, cmd);
    assign cls   = classify_cmd(cmd_q);

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) stack_i (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_mask (mask_q),
        .push_cond (push_cond),
        .top_mask  (top_mask),
        .top_cond  (top_cond),
        .empty     (empty),
        .full      (full)
    );

    simt_mask_next #(.LANES(LANES)) next_i (
        .cmd        (cmd_q),
        .cur_mask   (mask_q),
        .cond       (cond),
        .top_mask   (top_mask),
        .top_cond   (top_cond),
        .empty      (empty),
        .full       (full),
        .nxt_mask   (nxt_mask),
        .push_cond  (push_cond),
        .push       (push),
        .pop        (pop),
        .accepted   (accepted),
        .ovf_evt    (ovf_evt),
        .unf_evt    (unf_evt),
        .repeat_nxt (repeat_nxt)
    );

    simt_uniform_detect #(.LANES(LANES)) uni_i (
        .eval     (accepted && cls.applies_cond),
        .cur_mask (mask_q),
        .cond     (cond),
        .uniform  (uni_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            uni_q  <= 1'b0;
            rep_q  <= 1'b0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            mask_q <= nxt_mask;
            uni_q  <= uni_nxt;
            rep_q  <= repeat_nxt;
            ovf_q  <= ovf_q | ovf_evt;
            unf_q  <= unf_q | unf_evt;
        end
    end

    assign exec_mask     = mask_q;
    assign skip          = ~|mask_q;
    assign uniform       = uni_q;
    assign loop_repeat   = rep_q;
    assign err_overflow  = ovf_q;
    assign err_underflow = unf_q;

endmodule

// File: rtl/simt_mask_unit_chk.sv
module simt_mask_unit_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd,
    input logic [LANES-1:0] cond,
    input logic [LANES-1:0] exec_mask,
    input logic             skip,
    input logic             uniform,
    input logic             loop_repeat,
    input logic             err_overflow,
    input logic             err_underflow
);
    assert_loop_test_and_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == 3'd5) |=> (exec_mask == ($past(exec_mask) & $past(cond))));

    assert_open_subset_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd == 3'd1 || cmd == 3'd5)) |=> ((exec_mask & ~$past(exec_mask)) == '0));

    assert_open_zero_skips_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == 3'd1 && cond == '0 && !err_overflow) |=> (skip || err_overflow));

    assert_full_cond_uniform_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == 3'd1 && cond == '1 && !err_overflow) |=> (uniform || err_overflow));

    assert_loop_active_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == 3'd6 && exec_mask != '0) |=> $stable(exec_mask));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid) |=> ($stable(exec_mask) && !uniform && !loop_repeat));

    assert_no_overflow_clear_R9: assert property (@(posedge clk) disable iff (rst)
        err_overflow |=> err_overflow);

    assert_no_underflow_clear_R10: assert property (@(posedge clk) disable iff (rst)
        err_underflow |=> err_underflow);

endmodule

bind simt_mask_unit simt_mask_unit_chk #(.LANES(LANES)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd           (cmd),
    .cond          (cond),
    .exec_mask     (exec_mask),
    .skip          (skip),
    .uniform       (uniform),
    .loop_repeat   (loop_repeat),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
);

// File: tb/simt_mask_unit_tb_top.sv
`timescale 1ns/1ps
module simt_mask_unit_tb_top;
    localparam int LANES = 8;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd = 3'd0;
    logic [LANES-1:0] cond = '0;
    logic [LANES-1:0] exec_mask;
    logic             skip, uniform, loop_repeat, err_overflow, err_underflow;

    int n_checks = 0;
    int n_fails  = 0;

    logic [LANES-1:0] m_saved [DEPTH];
    logic [LANES-1:0] m_cond  [DEPTH];
    int               m_sp;
    logic [LANES-1:0] m_mask;
    logic             m_uni, m_rep, m_ovf, m_unf;

    always #10 clk = ~clk;

    simt_mask_unit #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .cond(cond),
        .exec_mask(exec_mask), .skip(skip), .uniform(uniform),
        .loop_repeat(loop_repeat), .err_overflow(err_overflow),
        .err_underflow(err_underflow)
    );

    function automatic logic ref_uniform(input logic [LANES-1:0] m, input logic [LANES-1:0] c);
        return ((m & c) == m) || ((m & c) == '0);
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sp = 0; m_mask = '1; m_uni = 0; m_rep = 0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic model_apply(input logic v, input logic [2:0] c, input logic [LANES-1:0] cd);
        int k;
        k = v ? int'(c) : 0;
        m_uni = 0; m_rep = 0;
        case (k)
            1, 4: begin
                if (m_sp == DEPTH) m_ovf = 1;
                else begin
                    m_saved[m_sp] = m_mask;
                    m_cond[m_sp]  = (k == 1) ? cd : '1;
                    m_sp++;
                    if (k == 1) begin
                        m_uni  = ref_uniform(m_mask, cd);
                        m_mask = m_mask & cd;
                    end
                end
            end
            2: if (m_sp == 0) m_unf = 1;
               else m_mask = m_saved[m_sp-1] & ~m_cond[m_sp-1];
            3: if (m_sp == 0) m_unf = 1;
               else begin m_mask = m_saved[m_sp-1]; m_sp--; end
            5: begin m_uni = ref_uniform(m_mask, cd); m_mask = m_mask & cd; end
            6: if (m_sp == 0) m_unf = 1;
               else if (m_mask != '0) m_rep = 1;
               else begin m_mask = m_saved[m_sp-1]; m_sp--; end
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic v, input logic [2:0] c);
        if (!v) return "R12";
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R7";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic compare_all(input string tag);
        check(exec_mask == m_mask, tag, 32'(exec_mask), 32'(m_mask));
        check(skip == (m_mask == '0), "R5 skip", 32'(skip), 32'(m_mask == '0));
        check(uniform == m_uni, "R6 uniform", 32'(uniform), 32'(m_uni));
        check(loop_repeat == m_rep, "R8 repeat", 32'(loop_repeat), 32'(m_rep));
        check(err_overflow == m_ovf, "R9 overflow", 32'(err_overflow), 32'(m_ovf));
        check(err_underflow == m_unf, "R10 underflow", 32'(err_underflow), 32'(m_unf));
    endtask

    task automatic step(input logic v, input logic [2:0] c, input logic [LANES-1:0] cd);
        cmd_valid = v; cmd = c; cond = cd;
        model_apply(v, c, cd);
        @(negedge clk);
        compare_all(tag_of(v, c));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; cmd_valid = 0; cmd = 0; cond = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        compare_all("R1 reset");
    endtask

    initial begin
        #(20ns * 150000);
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // nested conditional, R3 case: enclosing 0x0F, then 0x05, else 0x0A
        step(1, 3'd1, 8'h0F);
        step(1, 3'd1, 8'h05);
        check(exec_mask == 8'h05, "R2 nested open", 32'(exec_mask), 32'h05);
        step(1, 3'd2, 8'h00);
        check(exec_mask == 8'h0A, "R3 else mask", 32'(exec_mask), 32'h0A);
        step(1, 3'd3, 8'h00);
        check(exec_mask == 8'h0F, "R4 close restores", 32'(exec_mask), 32'h0F);
        step(1, 3'd3, 8'h00);
        // uniform condition and idle cycles
        step(1, 3'd1, 8'hFF);
        check(uniform == 1'b1, "R6 uniform open", 32'(uniform), 32'h1);
        step(0, 3'd1, 8'h00);
        step(1, 3'd7, 8'h00);
        step(1, 3'd0, 8'h00);
        step(1, 3'd3, 8'h00);
        // loop until no lane remains
        step(1, 3'd4, 8'h00);
        step(1, 3'd5, 8'h3F);
        step(1, 3'd6, 8'h00);
        check(loop_repeat == 1'b1, "R8 repeat", 32'(loop_repeat), 32'h1);
        step(1, 3'd5, 8'h03);
        step(1, 3'd6, 8'h00);
        step(1, 3'd5, 8'h00);
        check(skip == 1'b1, "R5 empty loop skip", 32'(skip), 32'h1);
        step(1, 3'd6, 8'h00);
        check(exec_mask == 8'hFF, "R8 loop exit restore", 32'(exec_mask), 32'hFF);
        // overflow
        for (int i = 0; i < DEPTH + 1; i++) step(1, 3'd4, 8'h00);
        check(err_overflow == 1'b1, "R9 overflow", 32'(err_overflow), 32'h1);
        for (int i = 0; i < DEPTH; i++) step(1, 3'd3, 8'h00);
        // underflow
        do_reset();
        step(1, 3'd2, 8'h00);
        check(err_underflow == 1'b1, "R10 underflow", 32'(err_underflow), 32'h1);
        step(1, 3'd6, 8'h00);
        // random segments
        for (int s = 0; s < 6; s++) begin
            do_reset();
            for (int n = 0; n < 400; n++) begin
                logic [LANES-1:0] cd;
                logic [2:0]       c;
                logic             v;
                v = ($urandom % 8) != 0;
                c = 3'($urandom_range(0, 7));
                case ($urandom % 4)
                    0: cd = '1;
                    1: cd = '0;
                    2: cd = m_mask | LANES'($urandom);
                    default: cd = LANES'($urandom);
                endcase
                step(v, c, cd);
            end
        end
        cmd_valid = 0;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule